// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block drives the scan timing of a raster LCD panel. Software programs a horizontal timing word, a vertical timing word, a polarity word and a control word through a small register write port. The block then produces horizontal sync, vertical sync, an active-video strobe (data enable), and the column and line index of the pixel being shown. Every count advances on a pixel clock enable, so the block can run from a fast system clock.

Each line is built from four parts in a fixed order: sync pulse, back porch, active pixels and front porch. Each frame follows the same order, counted in lines. Each timing field has its own encoding. Active width is given in units of 16 pixels. The horizontal fields and two of the vertical fields are stored minus one. The vertical porches are raw line counts and may be zero. New timing and polarity values are held in a staging copy. They reach the counters only when a frame ends, so a frame in progress is never torn. While the controller is disabled, the staging copy passes straight through.

Top module: `lcd_raster_timer`

## Requirements
- R1: A write happens on a rising clock edge with `cfg_we` high. `cfg_sel` picks the target: 0 is horizontal timing, 1 is vertical timing, 2 is polarity, 3 is control.
- R2: Horizontal word fields. Bits 7:2 give the active width as 16 × (n+1) pixels. Bits 15:8 give the hsync width as n+1. Bits 31:24 give the back porch as n+1. Bits 23:16 give the front porch as n+1.
- R3: Vertical word fields. Bits 9:0 give the active lines as n+1. Bits 15:10 give the vsync width as n+1. Bits 31:24 give the back porch as n lines. Bits 23:16 give the front porch as n lines. A value of zero gives no porch lines at all.
- R4: Each line runs sync, back porch, active, front porch. The line count advances on the pixel step that ends the horizontal front porch. Lines run in the same four-part order, and the frame wraps after the last front-porch line.
- R5: Data enable is active only when both the column and the line lie in their active regions.
- R6: `pix_x` is the offset from the first active pixel of the line and is 0 outside the active columns. `line_y` is the offset from the first active line and is 0 outside the active lines.
- R7: Polarity word bits. Bit 11 inverts vsync, bit 12 inverts hsync, and bit 14 inverts data enable. A clear bit means active high. Bit 13 is driven on `pclk_fall`.
- R8: Control bit 0 enables scanning. While it is clear, both counters are held at zero and all outputs sit at their inactive levels. Setting it starts a frame at the first sync pixel.
- R9: The counters move only on cycles where `pix_ce` is high.
- R10: While scanning, writes to the timing and polarity words take effect only when the current frame wraps. A write made in the wrapping cycle itself waits for the following frame. While disabled, such writes act at once.
- R11: After reset, all words are zero, so the block is disabled with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel clock enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable (active video) |
| pclk_fall | output | 1 | Selected pixel clock edge |
| pix_x | output | XW | Active column index |
| line_y | output | YW | Active line index |

## Verification
A register write and the frame wrap can land in the same clock. The bench provokes this by watching its own position count. It issues a vertical-word write on exactly the last pixel step of a frame. It then expects the next frame to keep the old vertical timing and the frame after it to use the new one. Every output is compared on every cycle against positions the bench computes arithmetically from the decoded fields. So the outcome is judged by whether the lengths of the sync, porch and active regions change one frame late and not early.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int XW = 10,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk_fall,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] line_y
);

  logic [29:0] sh_h, ac_h;
  logic [31:0] sh_v, ac_v;
  logic [3:0]  sh_p, ac_p;
  logic        run;

  logic [HW-1:0] hcnt, hsw_n, hst, hend, htot;
  logic [VW-1:0] vcnt, vsw_n, vst, vend, vtot;
  logic          hs_on, h_in, vs_on, v_in, h_last, v_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_h <= '0;
      sh_v <= '0;
      sh_p <= '0;
      run  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    sh_h <= cfg_wdata[31:2];
        2'd1:    sh_v <= cfg_wdata;
        2'd2:    sh_p <= cfg_wdata[14:11];
        default: run  <= cfg_wdata[0];
      endcase
    end
  end

  assign hsw_n = HW'(ac_h[13:6]) + HW'(1);
  assign hst   = hsw_n + HW'(ac_h[29:22]) + HW'(1);
  assign hend  = hst + ((HW'(ac_h[5:0]) + HW'(1)) << 4);
  assign htot  = hend + HW'(ac_h[21:14]) + HW'(1);

  assign vsw_n = VW'(ac_v[15:10]) + VW'(1);
  assign vst   = vsw_n + VW'(ac_v[31:24]);
  assign vend  = vst + VW'(ac_v[9:0]) + VW'(1);
  assign vtot  = vend + VW'(ac_v[23:16]);

  assign h_last = (hcnt == htot - HW'(1));
  assign v_last = (vcnt == vtot - VW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      ac_h <= '0;
      ac_v <= '0;
      ac_p <= '0;
    end else if (!run) begin
      hcnt <= '0;
      vcnt <= '0;
      ac_h <= sh_h;
      ac_v <= sh_v;
      ac_p <= sh_p;
    end else if (pix_ce) begin
      if (h_last) begin
        hcnt <= '0;
        if (v_last) begin
          vcnt <= '0;
          ac_h <= sh_h;
          ac_v <= sh_v;
          ac_p <= sh_p;
        end else begin
          vcnt <= vcnt + VW'(1);
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  assign hs_on = run && (hcnt < hsw_n);
  assign h_in  = run && (hcnt >= hst) && (hcnt < hend);
  assign vs_on = run && (vcnt < vsw_n);
  assign v_in  = run && (vcnt >= vst) && (vcnt < vend);

  assign vsync     = vs_on ^ ac_p[0];
  assign hsync     = hs_on ^ ac_p[1];
  assign pclk_fall = ac_p[2];
  assign de        = (h_in && v_in) ^ ac_p[3];
  assign pix_x     = h_in ? XW'(hcnt - hst) : '0;
  assign line_y    = v_in ? YW'(vcnt - vst) : '0;

endmodule

module lcd_raster_timer_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          pix_ce,
  input logic [HW-1:0] hcnt,
  input logic [HW-1:0] htot,
  input logic [VW-1:0] vcnt,
  input logic [VW-1:0] vtot,
  input logic [3:0]    pol,
  input logic          hsync,
  input logic          vsync,
  input logic          de
);

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt < htot) && (vcnt < vtot));

  // R4
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_ce && hcnt == htot - HW'(1)) |=> (hcnt == '0));

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_ce && hcnt != htot - HW'(1)) |=> $stable(vcnt));

  // R9
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pix_ce) |=> ($stable(hcnt) && $stable(vcnt)));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == '0 && vcnt == '0));

  // R5
  de_no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de ^ pol[3]) |-> (!(hsync ^ pol[1]) && !(vsync ^ pol[0])));

endmodule

bind lcd_raster_timer lcd_raster_timer_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pix_ce(pix_ce),
  .hcnt(hcnt), .htot(htot), .vcnt(vcnt), .vtot(vtot),
  .pol(ac_p), .hsync(hsync), .vsync(vsync), .de(de)
);

// File: tb/lcd_raster_timer_bench.sv
`timescale 1ns/1ps
module lcd_raster_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_ce = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hsync, vsync, de, pclk_fall;
  logic [9:0]  pix_x, line_y;

  int checks = 0;
  int fails = 0;
  int ce_mode = 0;
  int k = 0;
  string tag = "R11";

  always #2.5 clk = ~clk;

  lcd_raster_timer u_lcd_raster_timer (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync),
    .de(de), .pclk_fall(pclk_fall), .pix_x(pix_x), .line_y(line_y)
  );

  logic [31:0] s_h, s_v, s_p, s_c, a_h, a_v, a_p;
  int mh, mv;

  function automatic int f_htot(logic [31:0] h);
    return (int'(h[15:8]) + 1) + (int'(h[31:24]) + 1) + 16 * (int'(h[7:2]) + 1) + (int'(h[23:16]) + 1);
  endfunction

  function automatic int f_vtot(logic [31:0] v);
    return (int'(v[15:10]) + 1) + int'(v[31:24]) + (int'(v[9:0]) + 1) + int'(v[23:16]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s_h <= '0; s_v <= '0; s_p <= '0; s_c <= '0;
      a_h <= '0; a_v <= '0; a_p <= '0; mh <= 0; mv <= 0;
    end else begin
      if (!s_c[0]) begin
        mh <= 0; mv <= 0; a_h <= s_h; a_v <= s_v; a_p <= s_p;
      end else if (pix_ce) begin
        if (mh == f_htot(a_h) - 1) begin
          mh <= 0;
          if (mv == f_vtot(a_v) - 1) begin
            mv <= 0; a_h <= s_h; a_v <= s_v; a_p <= s_p;
          end else mv <= mv + 1;
        end else mh <= mh + 1;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: s_h <= cfg_wdata;
          2'd1: s_v <= cfg_wdata;
          2'd2: s_p <= cfg_wdata;
          default: s_c <= cfg_wdata;
        endcase
      end
    end
  end

  task automatic chk(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d (h=%0d v=%0d)", tag, name, act, exp, mh, mv);
    end
  endtask

  task automatic compare();
    int hsw = int'(a_h[15:8]) + 1;
    int hbp = int'(a_h[31:24]) + 1;
    int hact = 16 * (int'(a_h[7:2]) + 1);
    int vsw = int'(a_v[15:10]) + 1;
    int vbp = int'(a_v[31:24]);
    int vact = int'(a_v[9:0]) + 1;
    bit en = s_c[0];
    bit hin = en && mh >= hsw + hbp && mh < hsw + hbp + hact;
    bit vin = en && mv >= vsw + vbp && mv < vsw + vbp + vact;
    chk("hsync", int'(hsync), int'((en && mh < hsw) ^ a_p[12]));
    chk("vsync", int'(vsync), int'((en && mv < vsw) ^ a_p[11]));
    chk("de", int'(de), int'((hin && vin) ^ a_p[14]));
    chk("pclk_fall", int'(pclk_fall), int'(a_p[13]));
    chk("pix_x", int'(pix_x), hin ? mh - hsw - hbp : 0);
    chk("line_y", int'(line_y), vin ? mv - vsw - vbp : 0);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    compare();
    pix_ce = (ce_mode == 0) ? 1'b1 : (k % 3 != 0);
    k++;
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_run();
  end

  initial begin
    // R11: reset state
    tag = "R11";
    run_n(3);
    rst_n = 1'b1;
    run_n(3);
    // R1: configure while disabled
    tag = "R1";
    wr(2'd0, 32'h05050500);
    wr(2'd1, 32'h00000003);
    wr(2'd2, 32'h0);
    // R8: enable starts at sync
    tag = "R8";
    wr(2'd3, 32'h1);
    // R2 R3 R4 R5 R6: zero vertical porches, full-rate pixels
    tag = "R2 R3 R4 R5 R6";
    run_n(400);
    // R10: mid-frame writes deferred to frame wrap
    tag = "R10";
    wr(2'd0, 32'h05070604);
    wr(2'd1, 32'h01020402);
    wr(2'd2, 32'h00007800);
    run_n(300);
    // R7 R9: inverted polarity, gated pixel steps
    tag = "R7 R9";
    ce_mode = 1;
    run_n(1400);
    // R10: write in the wrapping cycle itself
    ce_mode = 0;
    tag = "R10";
    while (!(mh == f_htot(a_h) - 1 && mv == f_vtot(a_v) - 1 && pix_ce)) cyc();
    wr(2'd1, 32'h03000801);
    run_n(900);
    // R8: disable mid-frame
    tag = "R8";
    run_n(37);
    wr(2'd3, 32'h0);
    run_n(20);
    // R10: writes act at once while disabled
    tag = "R10";
    wr(2'd2, 32'h0);
    run_n(4);
    wr(2'd0, 32'h05050500);
    tag = "R8 R4";
    wr(2'd3, 32'h1);
    run_n(400);
    finish_run();
  end
endmodule